// File: doc/BRIEF.md
# Transmit Checksum Offload Engine

This engine sits on the transmit path of an Ethernet MAC. It takes a byte stream carrying one outgoing frame, holds the frame in a local buffer while it adds up the bytes, and then sends the frame on. Before forwarding, the engine can replace two bytes of the frame with a 16-bit ones' complement checksum. The byte stream carries no checksum offsets of its own. A short descriptor arrives first on a separate 32-bit control channel. It says whether to insert a checksum, where the summed region begins, where the result goes, and which 16-bit seed to add. Because this descriptor changes per frame, the same engine can serve IPv4, TCP or UDP layouts; the seed carries any pseudo-header partial sum that software has already computed.

The engine also polices frame length and drops frames while transmission is disabled. For every frame it actually sends, it adds the frame length to a 64-bit byte total and pulses a completion flag.

Top module: `tco_engine`

## Requirements
- R1: A descriptor is accepted only when its `ctl_last` beat is the fifth word. A transfer of any other length pulses `ctl_err` for one cycle, in the cycle after its last beat, and leaves the previously accepted descriptor in force.
- R2: Descriptor word 1 holds the first summed byte index in bits 31:16 and the checksum byte index in bits 15:0. Word 2 bits 15:0 hold the seed. Words 3 and 4 are ignored.
- R3: The checksum is formed as follows. Take the sum of 16-bit big-endian pairs, starting at the first summed byte and running to the frame end; a trailing odd byte takes a zero low half. Add the seed. Fold the 32-bit total to 16 bits twice, adding the carry back each time, then invert it.
- R4: The checksum high byte replaces the frame byte at the checksum index and the low byte replaces the next one. A position at or beyond the frame length is not written, and every other byte leaves unchanged.
- R5: When descriptor word 0 bit 0 is clear, the frame is forwarded byte for byte unchanged.
- R6: A frame whose final byte is accepted while `tx_enable` is low is consumed and discarded. It produces no output beat, no `tx_done` and no change to `tx_bytes`.
- R7: With `jumbo_en` and `vlan_en` both low, frames of 1519 to 1522 bytes are discarded. Frames of 1518 bytes or fewer, and frames longer than 1522 bytes, are sent. Raising either enable lets the 1519 to 1522 byte range through.
- R8: A frame longer than the buffer depth is discarded. A frame exactly as long as the buffer is sent.
- R9: Each sent frame adds its length to `tx_bytes` at its last output beat. `tx_done` is high for exactly the one following cycle, and `tx_bytes` does not change at any other time.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R11: After reset, `in_ready` is high, `out_valid` is low and `tx_bytes` is zero. `in_ready` is low whenever `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmission allowed; sampled at a frame's last byte |
| jumbo_en | input | 1 | Accept long frames; sampled at a frame's last byte |
| vlan_en | input | 1 | Accept tagged-length frames; sampled at a frame's last byte |
| ctl_valid | input | 1 | Descriptor word valid (always accepted) |
| ctl_data | input | 32 | Descriptor word |
| ctl_last | input | 1 | Final word of a descriptor transfer |
| ctl_err | output | 1 | One-cycle pulse on a wrong-length descriptor |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Engine accepts a frame byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte, checksum already inserted |
| out_last | output | 1 | Final forwarded byte |
| out_ready | input | 1 | Downstream accepts the byte |
| tx_bytes | output | 64 | Total bytes of all sent frames |
| tx_done | output | 1 | One-cycle pulse after each sent frame |

## Verification
The bench builds the engine with `DEPTH` = 1600 and leaves the other parameters at their defaults. This depth lets every length-policing frame between 1518 and 1530 bytes fit in the buffer. It also makes a 1601-byte frame the smallest one that overflows, so both sides of the overflow boundary need only about sixteen hundred bytes of stimulus. The seed and offset values are chosen to cover several cases: an odd start index, an all-ones frame that forces carries through both folds, and a checksum index at the last byte, so only the high half lands in the frame.

// File: rtl/tco_pkg.sv
package tco_pkg;

    // Byte offsets and frame lengths share one width
    localparam int unsigned OFS_W     = 16;
    localparam int unsigned HDR_WORDS = 5;
    localparam int unsigned CNT_W     = 64;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_FINISH = 2'd1,
        ST_DRAIN  = 2'd2
    } tco_state_e;

    typedef struct packed {
        logic             en;
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] ins;
        logic [15:0]      seed;
    } tco_hdr_t;

endpackage

// File: rtl/tco_hdr_capture.sv
module tco_hdr_capture
    import tco_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_valid,
    input  logic [31:0] ctl_data,
    input  logic        ctl_last,
    output tco_hdr_t    hdr_o,
    output logic        err_o
);

    localparam int unsigned CW = $clog2(HDR_WORDS + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        tco_hdr_t      stage;
        tco_hdr_t      hdr;
        logic          err;
    } hc_t;

    hc_t q, d;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (ctl_valid) begin
            unique case (q.cnt)
                CW'(0):  d.stage.en = ctl_data[0];
                CW'(1): begin
                    d.stage.start = ctl_data[31:16];
                    d.stage.ins   = ctl_data[15:0];
                end
                CW'(2):  d.stage.seed = ctl_data[15:0];
                default: ;
            endcase
            if (ctl_last) begin
                d.cnt = '0;
                if (q.cnt == CW'(HDR_WORDS - 1)) d.hdr = d.stage;
                else                             d.err = 1'b1;
            end else if (q.cnt != '1) begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hdr_o = q.hdr;
    assign err_o = q.err;

endmodule

// File: rtl/tco_csum_unit.sv
module tco_csum_unit
    import tco_pkg::*;
(
    input  logic [31:0]      acc_i,
    input  logic             first_i,
    input  logic [7:0]       data_i,
    input  logic [OFS_W-1:0] idx_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [15:0]      seed_i,
    output logic [31:0]      acc_o,
    output logic [15:0]      csum_o
);

    logic [31:0] base;
    logic        low_half;
    logic [31:0] total;
    logic [16:0] fold1;
    logic [16:0] fold2;

    always_comb begin
        base     = first_i ? 32'd0 : acc_i;
        low_half = idx_i[0] ^ start_i[0];
        if (idx_i >= start_i)
            acc_o = base + (low_half ? 32'(data_i) : (32'(data_i) << 8));
        else
            acc_o = base;

        total  = acc_i + 32'(seed_i);
        fold1  = {1'b0, total[15:0]} + {1'b0, total[31:16]};
        fold2  = {1'b0, fold1[15:0]} + 17'(fold1[16]);
        csum_o = ~fold2[15:0];
    end

endmodule

// File: rtl/tco_frame_buf.sv
module tco_frame_buf #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tco_engine.sv
module tco_engine
    import tco_pkg::*;
#(
    parameter int unsigned DEPTH   = 2048,
    parameter int unsigned STD_MAX = 1518,
    parameter int unsigned TAG_MAX = 1522
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_enable,
    input  logic             jumbo_en,
    input  logic             vlan_en,
    input  logic             ctl_valid,
    input  logic [31:0]      ctl_data,
    input  logic             ctl_last,
    output logic             ctl_err,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic [CNT_W-1:0] tx_bytes,
    output logic             tx_done
);

    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        tco_state_e       st;
        logic [OFS_W-1:0] len;
        logic [31:0]      acc;
        logic             drop;
        logic [OFS_W-1:0] rd;
        logic [15:0]      csum;
        tco_hdr_t         frm;
        logic [CNT_W-1:0] bytes;
        logic             done;
    } eng_t;

    eng_t q, d;

    tco_hdr_t         hdr;
    tco_hdr_t         hsel;
    logic [31:0]      acc_nxt;
    logic [15:0]      csum_val;
    logic [7:0]       buf_rdata;
    logic             buf_we;
    logic             in_fire;
    logic             first;
    logic             is_last;
    logic [OFS_W-1:0] len_inc;
    logic             police;

    tco_hdr_capture u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .ctl_last  (ctl_last),
        .hdr_o     (hdr),
        .err_o     (ctl_err)
    );

    assign first = (q.len == '0);
    assign hsel  = first ? hdr : q.frm;

    tco_csum_unit u_sum (
        .acc_i   (q.acc),
        .first_i (first),
        .data_i  (in_data),
        .idx_i   (q.len),
        .start_i (hsel.start),
        .seed_i  (q.frm.seed),
        .acc_o   (acc_nxt),
        .csum_o  (csum_val)
    );

    assign in_fire = (q.st == ST_FILL) && in_valid;
    assign buf_we  = in_fire && (q.len < OFS_W'(DEPTH));

    tco_frame_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.len[AW-1:0]),
        .wdata (in_data),
        .raddr (q.rd[AW-1:0]),
        .rdata (buf_rdata)
    );

    assign len_inc = (q.len == '1) ? q.len : q.len + OFS_W'(1);
    assign police  = !jumbo_en && !vlan_en &&
                     (len_inc > OFS_W'(STD_MAX)) && (len_inc <= OFS_W'(TAG_MAX));
    assign is_last = (q.rd == q.len - OFS_W'(1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_FILL: begin
                if (in_fire) begin
                    d.len  = len_inc;
                    d.acc  = acc_nxt;
                    d.drop = (first ? 1'b0 : q.drop) | (q.len >= OFS_W'(DEPTH));
                    if (first) d.frm = hdr;
                    if (in_last) begin
                        d.drop = d.drop | !tx_enable | police;
                        d.st   = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                if (q.drop) begin
                    d.st  = ST_FILL;
                    d.len = '0;
                end else begin
                    d.st   = ST_DRAIN;
                    d.rd   = '0;
                    d.csum = csum_val;
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    d.rd = q.rd + OFS_W'(1);
                    if (is_last) begin
                        d.st    = ST_FILL;
                        d.len   = '0;
                        d.bytes = q.bytes + CNT_W'(q.len);
                        d.done  = 1'b1;
                    end
                end
            end
            default: d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_FILL, default: '0};
        else        q <= d;
    end

    always_comb begin
        out_data = buf_rdata;
        if (q.frm.en) begin
            if (q.rd == q.frm.ins)
                out_data = q.csum[15:8];
            else if ({1'b0, q.rd} == {1'b0, q.frm.ins} + (OFS_W + 1)'(1))
                out_data = q.csum[7:0];
        end
    end

    assign in_ready  = (q.st == ST_FILL);
    assign out_valid = (q.st == ST_DRAIN);
    assign out_last  = out_valid && is_last;
    assign tx_bytes  = q.bytes;
    assign tx_done   = q.done;

endmodule

// File: rtl/tco_engine_chk.sv
module tco_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_valid,
    input logic        ctl_last,
    input logic        ctl_err,
    input logic        in_ready,
    input logic        out_valid,
    input logic [7:0]  out_data,
    input logic        out_last,
    input logic        out_ready,
    input logic [63:0] tx_bytes,
    input logic        tx_done
);

    assert_err_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> $past(ctl_valid && ctl_last));

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_no_fill_while_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_count_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (tx_bytes > $past(tx_bytes)));

    assert_count_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |-> $stable(tx_bytes));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

endmodule

bind tco_engine tco_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_valid (ctl_valid),
    .ctl_last  (ctl_last),
    .ctl_err   (ctl_err),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .tx_bytes  (tx_bytes),
    .tx_done   (tx_done)
);

// File: tb/sim_tco_engine.sv
`timescale 1ns/1ps
module sim_tco_engine;

    localparam int DEPTH = 1600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b1;
    logic        jumbo_en = 1'b0;
    logic        vlan_en = 1'b0;
    logic        ctl_valid = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        ctl_last = 1'b0;
    logic        ctl_err;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic [63:0] tx_bytes;
    logic        tx_done;

    tco_engine #(.DEPTH(DEPTH)) u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    longint     exp_bytes = 0;
    int         exp_done = 0, seen_done = 0;
    int         exp_err = 0, seen_err = 0;
    logic       bp_en = 1'b0;
    logic [7:0] lfsr = 8'hA7;

    logic        m_en = 1'b0;
    logic [15:0] m_start = '0, m_ins = '0, m_seed = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: set ready for the coming edge, then compare the beat it will take
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
            if (tx_done) seen_done++;
            if (ctl_err) seen_err++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected beat", {55'd0, out_last, out_data}, 64'h0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_last, out_data} == e, t, {55'd0, out_last, out_data}, {55'd0, e});
                end
            end
        end
    end

    function automatic logic [15:0] ref_csum(input logic [7:0] fr[$], input int st, input logic [15:0] seed);
        logic [31:0] s;
        logic [16:0] f1, f2;
        s = {16'h0, seed};
        for (int i = st; i < fr.size(); i++) begin
            if (((i - st) % 2) == 0) s += {16'h0, fr[i], 8'h0};
            else                     s += {24'h0, fr[i]};
        end
        f1 = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        f2 = {1'b0, f1[15:0]} + {16'h0, f1[16]};
        return ~f2[15:0];
    endfunction

    task automatic send_hdr(input logic en, input logic [15:0] st, input logic [15:0] ins,
                            input logic [15:0] seed, input int nw);
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);
            ctl_valid = 1'b1;
            ctl_data  = (w == 0) ? {31'h0, en} :
                        (w == 1) ? {st, ins} :
                        (w == 2) ? {16'hA5A5, seed} : (32'hDEAD0000 + 32'(w));
            ctl_last  = (w == nw - 1);
        end
        @(negedge clk);
        ctl_valid = 1'b0;
        ctl_last  = 1'b0;
        if (nw == 5) begin
            m_en = en; m_start = st; m_ins = ins; m_seed = seed;
        end else begin
            exp_err++;
        end
        repeat (2) @(negedge clk);
        chk(seen_err == exp_err, "R1 error pulse count", 64'(seen_err), 64'(exp_err));
    endtask

    task automatic send_frame(input int len, input int kind, input bit pass, input string tag);
        logic [7:0] fr[$];
        logic [7:0] ex[$];
        logic [15:0] cs;
        for (int i = 0; i < len; i++) begin
            fr.push_back(kind == 0 ? 8'((i * 7 + 3) & 255) :
                         kind == 1 ? 8'hFF : (8'(i) ^ 8'h5A));
        end
        ex = fr;
        if (pass) begin
            if (m_en) begin
                cs = ref_csum(fr, int'(m_start), m_seed);
                if (int'(m_ins) < len)     ex[m_ins]     = cs[15:8];
                if (int'(m_ins) + 1 < len) ex[m_ins + 1] = cs[7:0];
            end
            for (int i = 0; i < len; i++) begin
                exp_q.push_back({(i == len - 1), ex[i]});
                tag_q.push_back(tag);
            end
            exp_bytes += len;
            exp_done++;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            while (!in_ready) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = fr[i];
            in_last  = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(tx_bytes == 64'(exp_bytes), {tag, " R9 byte total"}, tx_bytes, 64'(exp_bytes));
        chk(seen_done == exp_done, {tag, " R9 done pulses"}, 64'(seen_done), 64'(exp_done));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'h0);
        chk(in_ready == 1'b1, "R11 reset in_ready", 64'(in_ready), 64'h1);
        chk(tx_bytes == 64'h0, "R11 reset tx_bytes", tx_bytes, 64'h0);

        send_hdr(1'b1, 16'd14, 16'd24, 16'h1234, 5);
        send_frame(60, 0, 1'b1, "R2 R3 R4 even");

        bp_en = 1'b1;
        send_hdr(1'b1, 16'd15, 16'd40, 16'h0000, 5);
        send_frame(61, 2, 1'b1, "R3 odd start and length R10");

        send_hdr(1'b1, 16'd0, 16'd39, 16'hFFFF, 5);
        send_frame(40, 1, 1'b1, "R3 carry fold R4 last index");

        send_hdr(1'b0, 16'd14, 16'd20, 16'h0000, 5);
        send_frame(50, 0, 1'b1, "R5 passthrough");

        send_hdr(1'b1, 16'd2, 16'd3, 16'h0007, 4);
        send_frame(50, 2, 1'b1, "R1 short descriptor ignored");
        send_hdr(1'b1, 16'd2, 16'd3, 16'h0007, 6);
        send_frame(33, 0, 1'b1, "R1 long descriptor ignored");

        send_hdr(1'b1, 16'd20, 16'd30, 16'h0100, 5);
        tx_enable = 1'b0;
        send_frame(64, 0, 1'b0, "R6 disabled drop");
        tx_enable = 1'b1;
        send_frame(64, 0, 1'b1, "R6 re-enabled R4");

        send_hdr(1'b1, 16'd14, 16'd50, 16'h0042, 5);
        send_frame(1519, 0, 1'b0, "R7 1519 drop");
        send_frame(1522, 2, 1'b0, "R7 1522 drop");
        send_frame(1518, 0, 1'b1, "R7 1518 pass");
        send_frame(1530, 2, 1'b1, "R7 1530 pass");
        vlan_en = 1'b1;
        send_frame(1522, 0, 1'b1, "R7 tagged 1522 pass");
        vlan_en = 1'b0;
        jumbo_en = 1'b1;
        send_frame(1520, 2, 1'b1, "R7 jumbo 1520 pass");
        send_frame(DEPTH + 1, 0, 1'b0, "R8 overflow drop");
        send_frame(DEPTH, 2, 1'b1, "R8 full buffer pass");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule